// File: doc/BRIEF.md
# Long Multiply Execution Unit

This unit executes a long integer multiply against a private file of eight data registers. A 16-bit control word selects four things: signed or unsigned arithmetic, a 32-bit or a 64-bit product, the low result register and the high result register. The multiplicand is read from the low result register. The multiplier arrives on a 32-bit source operand port together with a start strobe. The unit writes the product back and updates four condition flags: negative, zero, overflow and carry. It then raises a one-cycle done pulse.

The product comes from one of two multipliers, chosen by a parameter. One is a flat multiplier that answers in a single cycle. The other is a shift-and-add engine that works on magnitudes, takes one cycle per operand bit and corrects the sign at the end. Writeback always takes a separate cycle for each register. The low half is written first and the high half last, so the high half is left in a register named by both fields. A load port and a read port let the surrounding datapath place operands in the registers and observe results. When the load port and the multiply writeback target the same register in the same cycle, the multiply writeback wins.

Top module: `mul_long_unit`

## Requirements
- R1: Control word bit 11 = 1 gives a signed (two's complement) multiply, and bit 11 = 0 gives an unsigned multiply.
- R2: Control word bit 10 = 1 gives a 64-bit product written to two registers. Bit 10 = 0 gives a 32-bit result, and the register named by bits 2:0 is left unchanged.
- R3: Control word bits 14:12 name the low register. It supplies the multiplicand and receives product bits 31:0. Bits 2:0 name the high register, which receives product bits 63:32 in 64-bit mode.
- R4: In 64-bit mode the low register is written one cycle before the high register. When both fields name the same register, that register ends holding product bits 63:32.
- R5: The carry flag is 0 after every multiply.
- R6: In 64-bit mode, zero = (whole product == 0), negative = product bit 63, and overflow = 0.
- R7: In 32-bit signed mode, overflow = 1 exactly when product bits 63:31 are not all equal.
- R8: In 32-bit unsigned mode, overflow = 1 exactly when any of product bits 63:32 is 1.
- R9: In 32-bit mode, zero = (product bits 31:0 == 0) and negative = product bit 31.
- R10: done is high for exactly one cycle. It rises in the cycle after the last register and flag update, and at that point the read port and flags already show the results.
- R11: Synchronous active-high reset clears all eight registers, all flags and done.
- R12: A start pulse that arrives while a multiply is in progress is ignored. The running multiply finishes with its own operands and control word.
- R13: With ld_en high, ld_data is written to the register selected by ld_sel at the clock edge. rd_data shows the register selected by rd_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply (accepted when idle) |
| ext_word | input | 16 | Multiply control word |
| src_opnd | input | 32 | Multiplier operand |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register load index |
| ld_data | input | 32 | Register load value |
| rd_sel | input | 3 | Register read index |
| rd_data | output | 32 | Register read value |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The sweep crosses eight operand values in both operand positions under all four control modes. The values are zero, one, all ones, the largest positive, the most negative, a 16-bit mask and two mixed patterns. Together they separate signed from unsigned sign handling and show the 32-bit signed overflow boundary at bit 31 as distinct from the unsigned one at bit 32. They also show that the zero flag in 32-bit mode ignores a nonzero upper half. Directed cases then cover the same-register 64-bit writeback, the untouched high register in 32-bit mode, a second start strobe while busy, and the register contents and flags after reset.

// File: rtl/mul_long_pkg.sv
package mul_long_pkg;

   // Control word field positions
   localparam int CW_SIGNED_BIT = 11;
   localparam int CW_WIDE_BIT   = 10;
   localparam int CW_LO_MSB     = 14;
   localparam int CW_LO_LSB     = 12;
   localparam int CW_HI_MSB     = 2;
   localparam int CW_HI_LSB     = 0;
   localparam int SEL_W         = 3;

   typedef struct packed {
      logic             sgn;
      logic             wide;
      logic [SEL_W-1:0] lo_sel;
      logic [SEL_W-1:0] hi_sel;
   } mul_ctl_t;

   function automatic mul_ctl_t decode_ctl(input logic [15:0] cw);
      mul_ctl_t c;
      c.sgn    = cw[CW_SIGNED_BIT];
      c.wide   = cw[CW_WIDE_BIT];
      c.lo_sel = cw[CW_LO_MSB:CW_LO_LSB];
      c.hi_sel = cw[CW_HI_MSB:CW_HI_LSB];
      return c;
   endfunction

endpackage

// File: rtl/mul_long_regfile.sv
module mul_long_regfile #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 8,
   localparam int SW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wa_en,
   input  logic [SW-1:0]     wa_sel,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [SW-1:0]     wb_sel,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [SW-1:0]     ra_sel,
   output logic [DATA_W-1:0] ra_data,
   input  logic [SW-1:0]     rb_sel,
   output logic [DATA_W-1:0] rb_data
);

   logic [DATA_W-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else begin
         for (int i = 0; i < NREGS; i++) begin
            if (wa_en && wa_sel == SW'(i))
               regs[i] <= wa_data;
            else if (wb_en && wb_sel == SW'(i))
               regs[i] <= wb_data;
         end
      end
   end

   assign ra_data = regs[ra_sel];
   assign rb_data = regs[rb_sel];

   // A multiply write lands where it was aimed, even against a load
   AST_WA_LANDS: assert property (@(posedge clk) disable iff (rst)
      wa_en |=> regs[$past(wa_sel)] == $past(wa_data)); // R4

endmodule

// File: rtl/mul_long_core.sv
module mul_long_core #(
   parameter int DATA_W    = 32,
   parameter bit ITERATIVE = 1,
   localparam int PW       = 2 * DATA_W,
   localparam int CNT_W    = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic              sgn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              out_valid,
   output logic [PW-1:0]     prod
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mul_long_core: DATA_W must be at least 2");
      end

      if (ITERATIVE == 1'b0) begin : g_flat
         logic [PW-1:0] ax, bx;
         assign ax = sgn ? {{DATA_W{a[DATA_W-1]}}, a} : {{DATA_W{1'b0}}, a};
         assign bx = sgn ? {{DATA_W{b[DATA_W-1]}}, b} : {{DATA_W{1'b0}}, b};

         always_ff @(posedge clk) begin
            if (rst) begin
               out_valid <= 1'b0;
               prod      <= '0;
            end else begin
               out_valid <= go;
               if (go) prod <= ax * bx;
            end
         end
      end else begin : g_iter
         logic              busy;
         logic              neg;
         logic [CNT_W-1:0]  cnt;
         logic [PW-1:0]     acc, mc, acc_nx;
         logic [DATA_W-1:0] mp, a_mag, b_mag;
         logic              a_neg, b_neg;

         assign a_neg  = sgn & a[DATA_W-1];
         assign b_neg  = sgn & b[DATA_W-1];
         assign a_mag  = a_neg ? -a : a;
         assign b_mag  = b_neg ? -b : b;
         assign acc_nx = acc + (mp[0] ? mc : '0);

         always_ff @(posedge clk) begin
            if (rst) begin
               busy      <= 1'b0;
               neg       <= 1'b0;
               cnt       <= '0;
               acc       <= '0;
               mc        <= '0;
               mp        <= '0;
               out_valid <= 1'b0;
               prod      <= '0;
            end else begin
               out_valid <= 1'b0;
               if (go) begin
                  busy <= 1'b1;
                  neg  <= a_neg ^ b_neg;
                  cnt  <= CNT_W'(DATA_W);
                  acc  <= '0;
                  mc   <= {{DATA_W{1'b0}}, a_mag};
                  mp   <= b_mag;
               end else if (busy) begin
                  acc <= acc_nx;
                  mc  <= mc << 1;
                  mp  <= mp >> 1;
                  cnt <= cnt - 1'b1;
                  if (cnt == CNT_W'(1)) begin
                     busy      <= 1'b0;
                     out_valid <= 1'b1;
                     prod      <= neg ? -acc_nx : acc_nx;
                  end
               end
            end
         end
      end
   endgenerate

   AST_CORE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R10

endmodule

// File: rtl/mul_long_flags.sv
module mul_long_flags #(
   parameter int DATA_W = 32,
   localparam int PW    = 2 * DATA_W
) (
   input  logic [PW-1:0] prod,
   input  logic          sgn,
   input  logic          wide,
   output logic          n,
   output logic          z,
   output logic          v,
   output logic          c
);

   logic [DATA_W:0]   top_s;   // bits PW-1 .. DATA_W-1
   logic [DATA_W-1:0] top_u;   // bits PW-1 .. DATA_W
   logic              ovf_s, ovf_u;

   assign top_s = prod[PW-1:DATA_W-1];
   assign top_u = prod[PW-1:DATA_W];
   assign ovf_s = !((&top_s) || !(|top_s));
   assign ovf_u = |top_u;

   always_comb begin
      c = 1'b0;
      if (wide) begin
         n = prod[PW-1];
         z = (prod == '0);
         v = 1'b0;
      end else begin
         n = prod[DATA_W-1];
         z = (prod[DATA_W-1:0] == '0);
         v = sgn ? ovf_s : ovf_u;
      end
   end

endmodule

// File: rtl/mul_long_unit.sv
module mul_long_unit
   import mul_long_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREGS     = 8,
   parameter bit ITERATIVE = 1,
   localparam int PW       = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [15:0]       ext_word,
   input  logic [DATA_W-1:0] src_opnd,
   input  logic              ld_en,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);

   generate
      if (NREGS != (1 << SEL_W)) begin : g_bad_regs
         $error("mul_long_unit: NREGS must match the 3-bit register fields");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_WLO, ST_WHI} st_t;

   st_t               state;
   mul_ctl_t          ctl_in, ctl_q;
   logic              accept, commit;
   logic              core_valid;
   logic [PW-1:0]     prod;
   logic [DATA_W-1:0] opnd_a;
   logic              wa_en;
   logic [SEL_W-1:0]  wa_sel;
   logic [DATA_W-1:0] wa_data;
   logic              fn, fz, fv, fc;
   logic              unused_ext;

   assign ctl_in     = decode_ctl(ext_word);
   assign unused_ext = ^{ext_word[15], ext_word[9:3]};
   assign accept     = start && (state == ST_IDLE);
   assign commit     = (state == ST_WHI) || (state == ST_WLO && !ctl_q.wide);

   always_comb begin
      wa_en   = 1'b0;
      wa_sel  = ctl_q.lo_sel;
      wa_data = prod[DATA_W-1:0];
      if (state == ST_WLO) begin
         wa_en = 1'b1;
      end else if (state == ST_WHI) begin
         wa_en   = 1'b1;
         wa_sel  = ctl_q.hi_sel;
         wa_data = prod[PW-1:DATA_W];
      end
   end

   mul_long_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk    (clk),
      .rst    (rst),
      .wa_en  (wa_en),
      .wa_sel (wa_sel),
      .wa_data(wa_data),
      .wb_en  (ld_en),
      .wb_sel (ld_sel),
      .wb_data(ld_data),
      .ra_sel (ctl_in.lo_sel),
      .ra_data(opnd_a),
      .rb_sel (rd_sel),
      .rb_data(rd_data)
   );

   mul_long_core #(.DATA_W(DATA_W), .ITERATIVE(ITERATIVE)) u_core (
      .clk      (clk),
      .rst      (rst),
      .go       (accept),
      .sgn      (ctl_in.sgn),
      .a        (opnd_a),
      .b        (src_opnd),
      .out_valid(core_valid),
      .prod     (prod)
   );

   mul_long_flags #(.DATA_W(DATA_W)) u_flags (
      .prod(prod),
      .sgn (ctl_q.sgn),
      .wide(ctl_q.wide),
      .n   (fn),
      .z   (fz),
      .v   (fv),
      .c   (fc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         ctl_q  <= '0;
         done   <= 1'b0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
         flag_c <= 1'b0;
      end else begin
         done <= commit;
         if (commit) begin
            flag_n <= fn;
            flag_z <= fz;
            flag_v <= fv;
            flag_c <= fc;
         end
         unique case (state)
            ST_IDLE: if (accept) begin
               ctl_q <= ctl_in;
               state <= ST_MUL;
            end
            ST_MUL:  if (core_valid) state <= ST_WLO;
            ST_WLO:  state <= ctl_q.wide ? ST_WHI : ST_IDLE;
            ST_WHI:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WHI) |-> $past(state == ST_WLO)); // R4
   AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
      done |-> !flag_c); // R5
   AST_WIDE_NO_OVF: assert property (@(posedge clk) disable iff (rst)
      (done && ctl_q.wide) |-> !flag_v); // R6
   AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (done && ctl_q.wide) |-> (flag_z == (prod == '0))); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R10
   AST_BUSY_HOLDS_CTL: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE && start) |=> $stable(ctl_q)); // R12

endmodule

// File: tb/mul_long_unit_test.sv
module mul_long_unit_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        start;
   logic [15:0] ext_word;
   logic [31:0] src_opnd;
   logic        ld_en;
   logic [2:0]  ld_sel;
   logic [31:0] ld_data;
   logic [2:0]  rd_sel;
   logic [31:0] rd_data;
   logic        done, flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   mul_long_unit uut (
      .clk(clk), .rst(rst), .start(start), .ext_word(ext_word),
      .src_opnd(src_opnd), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .done(done),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: run hung, got %0d cycles expected below 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] mk_cw(input logic [2:0] lo, input logic [2:0] hi,
                                         input logic sg, input logic wide);
      return {1'b0, lo, sg, wide, 7'b0, hi};
   endfunction

   function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                            input logic sg);
      longint sa, sb;
      logic [63:0] ua, ub;
      if (sg) begin
         sa = longint'($signed(a));
         sb = longint'($signed(b));
         return 64'(sa * sb);
      end
      ua = {32'h0, a};
      ub = {32'h0, b};
      return ua * ub;
   endfunction

   task automatic rd(input logic [2:0] sel, output logic [31:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic load(input logic [2:0] sel, input logic [31:0] val);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_data = val;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // Issue a multiply, optionally with a stray start while busy, wait for done
   task automatic run(input logic [15:0] cw, input logic [31:0] src, input bit intrude);
      int n;
      @(negedge clk);
      start = 1'b1; ext_word = cw; src_opnd = src;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         @(negedge clk);
         start = 1'b1; ext_word = mk_cw(3'd7, 3'd6, 1'b0, 1'b1); src_opnd = 32'h0000_0003;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R10 done seen", {63'd0, done}, 64'd1);
   endtask

   task automatic check_done_drop();
      @(negedge clk);
      chk("R10 done one cycle", {63'd0, done}, 64'd0);
   endtask

   // Full sweep step: all flags and registers checked at the done cycle
   task automatic sweep_op(input logic [31:0] a, input logic [31:0] b,
                           input logic sg, input logic wide,
                           input logic [2:0] lo, input logic [2:0] hi);
      logic [63:0] p;
      logic [31:0] v_lo, v_hi;
      logic en, ez, ev;
      string tag;
      load(hi, 32'hA5A5_5A5A);
      load(lo, a);
      run(mk_cw(lo, hi, sg, wide), b, 1'b0);
      p = ref_prod(a, b, sg);
      if (wide) begin
         en = p[63]; ez = (p == 64'd0); ev = 1'b0;
         tag = sg ? "R6 R1 wide signed flags" : "R6 R1 wide unsigned flags";
      end else begin
         en = p[31]; ez = (p[31:0] == 32'd0);
         ev = sg ? !((&p[63:31]) || !(|p[63:31])) : (|p[63:32]);
         tag = sg ? "R7 R9 narrow signed flags" : "R8 R9 narrow unsigned flags";
      end
      chk(tag, {61'd0, flag_n, flag_z, flag_v}, {61'd0, en, ez, ev});
      chk("R5 carry", {63'd0, flag_c}, 64'd0);
      rd(lo, v_lo);
      rd(hi, v_hi);
      chk("R3 low register", {32'd0, v_lo}, {32'd0, p[31:0]});
      if (wide) chk("R2 R3 high register", {32'd0, v_hi}, {32'd0, p[63:32]});
      else      chk("R2 high register untouched", {32'd0, v_hi}, 64'h0000_0000_A5A5_5A5A);
      check_done_drop();
   endtask

   initial begin
      logic [31:0] vals [8];
      logic [31:0] got;
      logic [63:0] p;
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
      vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
      vals[4] = 32'h8000_0000; vals[5] = 32'h0000_FFFF;
      vals[6] = 32'h1234_5678; vals[7] = 32'hDEAD_BEEF;

      rst = 1'b1; start = 1'b0; ext_word = '0; src_opnd = '0;
      ld_en = 1'b0; ld_sel = '0; ld_data = '0; rd_sel = '0;

      // R11: load nonzero data, then reset, then everything reads zero
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      load(3'd2, 32'hCAFE_F00D);
      rd(3'd2, got);
      chk("R13 load then read", {32'd0, got}, 64'h0000_0000_CAFE_F00D);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      for (int r = 0; r < 8; r++) begin
         rd(3'(r), got);
         chk("R11 register cleared", {32'd0, got}, 64'd0);
      end
      chk("R11 flags and done cleared",
          {59'd0, done, flag_n, flag_z, flag_v, flag_c}, 64'd0);

      // Main sweep over operand pairs and all four modes
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               logic [2:0] lo_r, hi_r;
               lo_r = 3'((i + j + m) % 8);
               hi_r = 3'((i + j + m + 3) % 8);
               sweep_op(vals[i], vals[j], m[0], m[1], lo_r, hi_r);
            end
         end
      end

      // R4: same register named twice in wide mode keeps the upper half
      load(3'd5, 32'h1234_5678);
      run(mk_cw(3'd5, 3'd5, 1'b1, 1'b1), 32'h9ABC_DEF0, 1'b0);
      p = ref_prod(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
      rd(3'd5, got);
      chk("R4 same register signed", {32'd0, got}, {32'd0, p[63:32]});
      check_done_drop();
      load(3'd0, 32'hFFFF_FFFF);
      run(mk_cw(3'd0, 3'd0, 1'b0, 1'b1), 32'h0000_0002, 1'b0);
      rd(3'd0, got);
      chk("R4 same register unsigned", {32'd0, got}, 64'd1);
      check_done_drop();

      // R12: stray start while busy does not disturb the running multiply
      load(3'd7, 32'h0000_0011);
      load(3'd6, 32'h5555_5555);
      load(3'd1, 32'h0001_0000);
      run(mk_cw(3'd1, 3'd4, 1'b0, 1'b1), 32'h0003_0000, 1'b1);
      rd(3'd1, got);
      chk("R12 running result low", {32'd0, got}, 64'd0);
      rd(3'd4, got);
      chk("R12 running result high", {32'd0, got}, 64'd3);
      rd(3'd6, got);
      chk("R12 stray target untouched", {32'd0, got}, 64'h0000_0000_5555_5555);
      rd(3'd7, got);
      chk("R12 stray source untouched", {32'd0, got}, 64'd17);
      check_done_drop();
      repeat (40) @(negedge clk);
      chk("R12 no second done", {63'd0, done}, 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule